// File: doc/BRIEF.md
# FIFO Depth-Expansion Token Controller

This block sits beside one FIFO storage slice and decides whether that slice may accept writes and deliver reads when several slices are chained into one deeper FIFO. Two tokens travel around a ring of slices, one for writing and one for reading. The slice that holds the write token takes the incoming words. When it stores a word in its last physical location, it hands the write token to the next slice. The read token moves around the ring in the same way, handed on when a read empties the last physical location. Each slice's expansion-out pulse is wired to the expansion-in of the next slice, and the last slice feeds the first.

A strap input marks the first slice in the ring; after reset only that slice owns both tokens. The controller also gates the slice's output drivers, so that only the read-token owner drives the shared data bus when output enable is active. One output pin is shared between the write-expansion pulse (when cascaded) and the slice's half-full flag (when standalone). A small helper module merges per-slice status flags into composite ring-wide flags.

Top module: `fifo_cascade_token_ctrl`

## Requirements
- R1: While `rstN` is low at a rising clock edge, a slice with `firstLoadN` = 0 takes both tokens and a slice with `firstLoadN` = 1 takes neither. Both expansion pulses are cleared.
- R2: `writeAllow` is high exactly when the slice holds the write token, and `readAllow` is high exactly when it holds the read token.
- R3: An edge that sees `wrStrobe`, `wrLastLoc` and the write token all high releases the write token at that edge and raises `wxOut` for exactly one clock.
- R4: A write strobe without the write token, or without `wrLastLoc`, leaves the write token unchanged and raises no `wxOut` pulse.
- R5: An edge that samples `wxIn` high gives the slice the write token.
- R6: An edge that sees `rdStrobe`, `rdLastLoc` and the read token all high releases the read token and raises `rxOut` for exactly one clock. Without the token or without `rdLastLoc`, nothing changes.
- R7: An edge that samples `rxIn` high gives the slice the read token. Read and write tokens move independently of each other.
- R8: `dataDrive` is high only when `outEnable` is high and the slice holds the read token.
- R9: `wxoHfOut` carries `wxOut` when `cascadeEn` = 1 and carries `halfFullIn` when `cascadeEn` = 0.
- R10: Each composite flag of the merge helper (bit i = slice i, active high) is high only when that flag is high in every slice.
- R11: In a correctly wired ring, at most one slice holds the write token and at most one holds the read token at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the ring |
| rstN | input | 1 | Synchronous reset, active low |
| firstLoadN | input | 1 | Strap; low marks the first slice of the ring |
| cascadeEn | input | 1 | Selects cascade use of the shared pin |
| wxIn | input | 1 | Write token arrival from the previous slice |
| rxIn | input | 1 | Read token arrival from the previous slice |
| wrStrobe | input | 1 | Ring-wide write request |
| rdStrobe | input | 1 | Ring-wide read request |
| wrLastLoc | input | 1 | The current write targets this slice's last location |
| rdLastLoc | input | 1 | The current read takes this slice's last location |
| outEnable | input | 1 | Ring-wide output enable |
| halfFullIn | input | 1 | Slice half-full status for standalone use |
| writeAllow | output | 1 | Slice may accept the write |
| readAllow | output | 1 | Slice may serve the read |
| wxOut | output | 1 | One-cycle write token hand-off pulse |
| rxOut | output | 1 | One-cycle read token hand-off pulse |
| wxoHfOut | output | 1 | Shared pin: hand-off pulse or half-full |
| dataDrive | output | 1 | Enable for the slice's data output drivers |

## Verification
The bench builds a ring of three slices and walks both tokens twice around it. After each hand-off it checks that the tokens have moved on. A design that kept a token after firing would show two owners at once. A design that stretched the pulse would pass the token on twice. Write strobes are aimed at slices that do not own the token but flag their last location, to catch a design that fires without ownership. The bench also fires at the owner's non-last locations, to catch a design that ignores the last-location qualifier. Other checks confirm that the read token stays put while the write token circulates, that the data drivers follow the read owner, that the shared pin switches source, and that reset in the middle of operation returns both tokens to the strap-selected slice.

// File: rtl/fifo_cascade_pkg.sv
package fifo_cascade_pkg;
  localparam int NUM_CHAN = 2;  // channel 0 = write token, channel 1 = read token
  localparam int CH_WR = 0;
  localparam int CH_RD = 1;

  typedef struct packed {
    logic [NUM_CHAN-1:0] fire;  // token released, hand-off pulse due
    logic [NUM_CHAN-1:0] take;  // token arriving from previous slice
  } tokStrobe_t;
endpackage

// File: rtl/fifo_cascade_flag_merge.sv
module fifo_cascade_flag_merge #(
  parameter int NUM_SLICES = 3
) (
  input  logic [NUM_SLICES-1:0] emptyVec,
  input  logic [NUM_SLICES-1:0] fullVec,
  input  logic [NUM_SLICES-1:0] almostEmptyVec,
  input  logic [NUM_SLICES-1:0] almostFullVec,
  output logic                  allEmpty,
  output logic                  allFull,
  output logic                  allAlmostEmpty,
  output logic                  allAlmostFull
);
  // Active-high flags: the ring shows a condition only when every slice does.
  assign allEmpty       = &emptyVec;
  assign allFull        = &fullVec;
  assign allAlmostEmpty = &almostEmptyVec;
  assign allAlmostFull  = &almostFullVec;
endmodule

// File: rtl/fifo_cascade_tok_ctrl.sv
module fifo_cascade_tok_ctrl
  import fifo_cascade_pkg::*;
(
  input  logic                wrStrobe,
  input  logic                rdStrobe,
  input  logic                wrLastLoc,
  input  logic                rdLastLoc,
  input  logic                wxIn,
  input  logic                rxIn,
  input  logic [NUM_CHAN-1:0] tokHeld,
  output tokStrobe_t          strobes
);
  logic [NUM_CHAN-1:0] reqVec;
  logic [NUM_CHAN-1:0] lastVec;
  logic [NUM_CHAN-1:0] arriveVec;

  assign reqVec    = {rdStrobe, wrStrobe};
  assign lastVec   = {rdLastLoc, wrLastLoc};
  assign arriveVec = {rxIn, wxIn};

  always_comb begin
    for (int ch = 0; ch < NUM_CHAN; ch++) begin
      strobes.fire[ch] = reqVec[ch] & lastVec[ch] & tokHeld[ch];
      strobes.take[ch] = arriveVec[ch];
    end
  end
endmodule

// File: rtl/fifo_cascade_tok_dp.sv
module fifo_cascade_tok_dp
  import fifo_cascade_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                firstLoadN,
  input  tokStrobe_t          strobes,
  input  logic                outEnable,
  input  logic                cascadeEn,
  input  logic                halfFullIn,
  output logic [NUM_CHAN-1:0] tokHeld,
  output logic [NUM_CHAN-1:0] pulseOut,
  output logic                wxoHfOut,
  output logic                dataDrive
);
  genvar ch;
  generate
    for (ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      logic tokQ;
      logic pulseQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tokQ   <= ~firstLoadN;
          pulseQ <= 1'b0;
        end else begin
          tokQ   <= (tokQ & ~strobes.fire[ch]) | strobes.take[ch];
          pulseQ <= strobes.fire[ch];
        end
      end
      assign tokHeld[ch]  = tokQ;
      assign pulseOut[ch] = pulseQ;
    end
  endgenerate

  assign wxoHfOut  = cascadeEn ? pulseOut[CH_WR] : halfFullIn;
  assign dataDrive = outEnable & tokHeld[CH_RD];
endmodule

// File: rtl/fifo_cascade_token_ctrl.sv
module fifo_cascade_token_ctrl
  import fifo_cascade_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic firstLoadN,
  input  logic cascadeEn,
  input  logic wxIn,
  input  logic rxIn,
  input  logic wrStrobe,
  input  logic rdStrobe,
  input  logic wrLastLoc,
  input  logic rdLastLoc,
  input  logic outEnable,
  input  logic halfFullIn,
  output logic writeAllow,
  output logic readAllow,
  output logic wxOut,
  output logic rxOut,
  output logic wxoHfOut,
  output logic dataDrive
);
  tokStrobe_t          strobes;
  logic [NUM_CHAN-1:0] tokHeld;
  logic [NUM_CHAN-1:0] pulseOut;

  fifo_cascade_tok_ctrl ctrl_i (
    .wrStrobe (wrStrobe),
    .rdStrobe (rdStrobe),
    .wrLastLoc(wrLastLoc),
    .rdLastLoc(rdLastLoc),
    .wxIn     (wxIn),
    .rxIn     (rxIn),
    .tokHeld  (tokHeld),
    .strobes  (strobes)
  );

  fifo_cascade_tok_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .firstLoadN(firstLoadN),
    .strobes   (strobes),
    .outEnable (outEnable),
    .cascadeEn (cascadeEn),
    .halfFullIn(halfFullIn),
    .tokHeld   (tokHeld),
    .pulseOut  (pulseOut),
    .wxoHfOut  (wxoHfOut),
    .dataDrive (dataDrive)
  );

  assign writeAllow = tokHeld[CH_WR];
  assign readAllow  = tokHeld[CH_RD];
  assign wxOut      = pulseOut[CH_WR];
  assign rxOut      = pulseOut[CH_RD];
endmodule

// File: rtl/fifo_cascade_token_chk.sv
module fifo_cascade_token_chk (
  input logic clk,
  input logic rstN,
  input logic wxIn,
  input logic rxIn,
  input logic wrStrobe,
  input logic rdStrobe,
  input logic wrLastLoc,
  input logic rdLastLoc,
  input logic outEnable,
  input logic writeAllow,
  input logic readAllow,
  input logic wxOut,
  input logic rxOut,
  input logic dataDrive
);
  AST_WR_FIRE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrLastLoc && writeAllow && !wxIn) |=> (wxOut && !writeAllow)); // R3
  AST_WX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wxOut |=> !wxOut); // R3
  AST_WX_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rstN)
    !writeAllow |=> !wxOut); // R4
  AST_WR_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    wxIn |=> writeAllow); // R5
  AST_RD_FIRE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdLastLoc && readAllow && !rxIn) |=> (rxOut && !readAllow)); // R6
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxOut |=> !rxOut); // R6
  AST_RD_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    rxIn |=> readAllow); // R7
  AST_DRIVE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    dataDrive |-> (readAllow && outEnable)); // R8
endmodule

bind fifo_cascade_token_ctrl fifo_cascade_token_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wxIn      (wxIn),
  .rxIn      (rxIn),
  .wrStrobe  (wrStrobe),
  .rdStrobe  (rdStrobe),
  .wrLastLoc (wrLastLoc),
  .rdLastLoc (rdLastLoc),
  .outEnable (outEnable),
  .writeAllow(writeAllow),
  .readAllow (readAllow),
  .wxOut     (wxOut),
  .rxOut     (rxOut),
  .dataDrive (dataDrive)
);

// File: tb/fifo_cascade_token_ctrl_tb.sv
module fifo_cascade_token_ctrl_tb_top;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic [NS-1:0] firstLoadN;
  logic          cascadeEn, wrStrobe, rdStrobe, outEnable, halfFullIn;
  logic [NS-1:0] wrLast, rdLast;
  logic [NS-1:0] writeAllow, readAllow, wxOut, rxOut, wxoHf, dataDrive;

  logic [NS-1:0] emptyVec, fullVec, aeVec, afVec;
  logic          allEmpty, allFull, allAe, allAf;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int expW = 0;
  int expR = 0;

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_slice
      fifo_cascade_token_ctrl dut_i (
        .clk       (clk),
        .rstN      (rstN),
        .firstLoadN(firstLoadN[gi]),
        .cascadeEn (cascadeEn),
        .wxIn      (wxOut[(gi+NS-1)%NS]),
        .rxIn      (rxOut[(gi+NS-1)%NS]),
        .wrStrobe  (wrStrobe),
        .rdStrobe  (rdStrobe),
        .wrLastLoc (wrLast[gi]),
        .rdLastLoc (rdLast[gi]),
        .outEnable (outEnable),
        .halfFullIn(halfFullIn),
        .writeAllow(writeAllow[gi]),
        .readAllow (readAllow[gi]),
        .wxOut     (wxOut[gi]),
        .rxOut     (rxOut[gi]),
        .wxoHfOut  (wxoHf[gi]),
        .dataDrive (dataDrive[gi])
      );
    end
  endgenerate

  fifo_cascade_flag_merge #(.NUM_SLICES(NS)) merge_i (
    .emptyVec      (emptyVec),
    .fullVec       (fullVec),
    .almostEmptyVec(aeVec),
    .almostFullVec (afVec),
    .allEmpty      (allEmpty),
    .allFull       (allFull),
    .allAlmostEmpty(allAe),
    .allAlmostFull (allAf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] oneHot(input int idx);
    return NS'(1) << idx;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rstN = 1'b0;
    wrStrobe = 0; rdStrobe = 0; wrLast = '0; rdLast = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expW = 0; expR = 0;
    @(negedge clk);
    chk("R1 write token after reset", writeAllow, 3'b001);
    chk("R1 read token after reset", readAllow, 3'b001);
    chk("R1 wx pulses cleared", wxOut, 3'b000);
    chk("R1 rx pulses cleared", rxOut, 3'b000);
  endtask

  task automatic t_no_fire();
    // owner writes to non-last locations; non-owners flag last location
    @(negedge clk);
    wrStrobe = 1'b1;
    wrLast = ~oneHot(expW);
    repeat (3) begin
      @(negedge clk);
      chk("R4 no release without last/token", writeAllow, oneHot(expW));
      chk("R4 no pulse without last/token", wxOut, 3'b000);
    end
    wrStrobe = 1'b0; wrLast = '0;
    rdStrobe = 1'b1; rdLast = ~oneHot(expR);
    @(negedge clk);
    chk("R6 no read release without last/token", readAllow, oneHot(expR));
    chk("R6 no rx pulse without last/token", rxOut, 3'b000);
    rdStrobe = 1'b0; rdLast = '0;
  endtask

  task automatic t_write_ring(input int hops);
    for (int k = 0; k < hops; k++) begin
      int nxt;
      nxt = (expW + 1) % NS;
      wrStrobe = 1'b1; wrLast = oneHot(expW);
      @(negedge clk);
      wrStrobe = 1'b0; wrLast = '0;
      chk("R3 write token released", writeAllow, 3'b000);
      chk("R3 wx pulse from owner", wxOut, oneHot(expW));
      if (cascadeEn) chk("R9 shared pin carries wx", wxoHf, oneHot(expW));
      @(negedge clk);
      chk("R5 next slice gains write token", writeAllow, oneHot(nxt));
      chk("R3 wx pulse one cycle", wxOut, 3'b000);
      chk("R11 one write owner", $countones(writeAllow), 1);
      chk("R7 read token untouched by writes", readAllow, oneHot(expR));
      expW = nxt;
    end
  endtask

  task automatic t_read_ring(input int hops);
    for (int k = 0; k < hops; k++) begin
      int nxt;
      nxt = (expR + 1) % NS;
      rdStrobe = 1'b1; rdLast = oneHot(expR);
      @(negedge clk);
      rdStrobe = 1'b0; rdLast = '0;
      chk("R6 read token released", readAllow, 3'b000);
      chk("R6 rx pulse from owner", rxOut, oneHot(expR));
      chk("R8 no driver during gap", outEnable ? dataDrive : 3'b000, 3'b000);
      @(negedge clk);
      chk("R7 next slice gains read token", readAllow, oneHot(nxt));
      chk("R6 rx pulse one cycle", rxOut, 3'b000);
      chk("R2 write allow stable during reads", writeAllow, oneHot(expW));
      chk("R11 one read owner", $countones(readAllow), 1);
      expR = nxt;
    end
  endtask

  task automatic t_drive();
    outEnable = 1'b1;
    @(negedge clk);
    chk("R8 drive follows read owner", dataDrive, oneHot(expR));
    t_read_ring(1);
    chk("R8 drive moved with token", dataDrive, oneHot(expR));
    outEnable = 1'b0;
    @(negedge clk);
    chk("R8 drive off without output enable", dataDrive, 3'b000);
  endtask

  task automatic t_shared_pin();
    cascadeEn = 1'b0; halfFullIn = 1'b1;
    @(negedge clk);
    chk("R9 standalone pin shows half-full", wxoHf, 3'b111);
    halfFullIn = 1'b0;
    @(negedge clk);
    chk("R9 standalone pin shows half-full low", wxoHf, 3'b000);
    cascadeEn = 1'b1; halfFullIn = 1'b1;
    @(negedge clk);
    chk("R9 cascade pin ignores half-full", wxoHf, 3'b000);
    t_write_ring(1);
    halfFullIn = 1'b0;
  endtask

  task automatic t_merge();
    emptyVec = 3'b111; fullVec = 3'b011; aeVec = 3'b101; afVec = 3'b000;
    #1;
    chk("R10 all empty", allEmpty, 1);
    chk("R10 full needs every slice", allFull, 0);
    chk("R10 almost empty needs every slice", allAe, 0);
    chk("R10 almost full low", allAf, 0);
    fullVec = 3'b111; afVec = 3'b111; emptyVec = 3'b110;
    #1;
    chk("R10 all full", allFull, 1);
    chk("R10 all almost full", allAf, 1);
    chk("R10 empty cleared by one slice", allEmpty, 0);
  endtask

  task automatic t_reset_midway();
    t_write_ring(1);
    t_read_ring(2);
    t_reset();
  endtask

  initial begin
    rstN = 1'b0; firstLoadN = 3'b110;
    cascadeEn = 1'b1; wrStrobe = 0; rdStrobe = 0; outEnable = 0; halfFullIn = 0;
    wrLast = '0; rdLast = '0;
    emptyVec = '0; fullVec = '0; aeVec = '0; afVec = '0;
    t_reset();
    t_no_fire();
    t_write_ring(2 * NS);
    t_read_ring(2 * NS);
    t_write_ring(2);
    t_no_fire();
    t_drive();
    t_shared_pin();
    t_merge();
    t_reset_midway();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule